// File: doc/BRIEF.md
# Unlock-Sequence Flash Bank Sequencer

This block drives a byte-wide parallel flash that only accepts a command after a fixed pair of unlock writes. On a start request it either erases or programs one whole bank, selected from two. Each bank occupies a power-of-two window of `BANK_BYTES` bytes (8 KB by default), and the bank base address is the bank number times the bank size. A program operation takes its bytes from an external source buffer through a byte read port. After each erase command, and after each programmed byte, the sequencer waits for the flash to finish. It reads the bank base twice in a row and checks whether one status bit changed between the two reads.

When the erase or programming phase ends, the sequencer reads back the whole bank. After an erase every byte must be 0xFF. After a program every byte must equal the source byte. The result is one `done_o` pulse, together with a timeout flag and a verify-fail flag. Both flags stay valid until the next accepted start.

Top module: `flash_bank_seq`

## Requirements
- R1: After reset, busy_o, done_o, timeout_o, verify_fail_o, flash_we_o and flash_re_o are all 0.
- R2: start_i is accepted only while busy_o is 0, and busy_o is 1 from the next cycle until the operation ends. A start_i while busy_o is 1 has no effect on the operation in progress.
- R3: An erase (op_i = 0) writes exactly six bytes, one per cycle, at offsets relative to the bank base. The sequence is 0xAA at 0x555, 0x55 at 0x2AA, 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA, and then 0x30 at offset 0.
- R4: A program (op_i = 1) handles bank offsets 0 to BANK_BYTES-1 in ascending order. For each offset it writes 0xAA at 0x555, 0x55 at 0x2AA and 0xA0 at 0x555. It then writes the source byte (src_data_i while src_addr_o equals that offset) at that offset. Flash address bit OFS_W carries the bank number.
- R5: After each command sequence the sequencer reads the bank base twice in a row. If bit 6 of the XOR of the two values is 0, the step is complete. Otherwise the pair of reads is repeated.
- R6: If TIMEOUT_POLLS consecutive read pairs all show bit 6 differing, the operation ends with timeout_o = 1 and no verification. A pair that matches on the last allowed poll completes normally.
- R7: After an erase, every byte of the bank is read in turn and compared with 0xFF. The first mismatch ends the operation with verify_fail_o = 1.
- R8: After a program, every byte is read in turn and compared with the source byte. The operation stops at the first mismatching offset with verify_fail_o = 1.
- R9: done_o is a one-cycle pulse in the first cycle with busy_o = 0. timeout_o and verify_fail_o hold their result until the cycle after the next accepted start, when they read 0.
- R10: flash_we_o and flash_re_o are never 1 together, and during an operation every flash access stays inside the selected bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| op_i | input | 1 | 0 = erase, 1 = program |
| bank_i | input | BANK_W | Bank number |
| src_addr_o | output | OFS_W | Source buffer byte address |
| src_data_i | input | 8 | Source buffer byte (combinational from src_addr_o) |
| flash_addr_o | output | ADDR_W | Flash byte address |
| flash_wdata_o | output | 8 | Flash write data |
| flash_we_o | output | 1 | Flash write strobe, one byte per cycle |
| flash_re_o | output | 1 | Flash read strobe |
| flash_rdata_i | input | 8 | Flash read data, valid the cycle after flash_re_o |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | End-of-operation pulse |
| timeout_o | output | 1 | Last operation ended on poll timeout |
| verify_fail_o | output | 1 | Last operation failed read-back |

## Verification
Two events can land on the same cycle: the end-of-operation pulse and a new start request. The pulse cycle is already idle, so a start presented there must be accepted. The bench raises start_i exactly in the cycle where done_o is seen. It then expects busy_o one cycle later, cleared flags, and the complete write sequence of the new operation. The poll counter's expiry and a completed poll pair can also meet on the same read pair. The flash model is given a busy time of exactly 2·TIMEOUT_POLLS-2 reads, where completion must win, and 2·TIMEOUT_POLLS reads, where the timeout must fire. Each case is judged by the flags and the exact number of flash reads.

// File: rtl/fsq_pkg.sv
`timescale 1ns/1ps
package fsq_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_CMD, S_POLL_A, S_POLL_B, S_POLL_C, S_VRD, S_VCMP
   } fsq_state_e;

   // command bytes and unlock offsets relative to the bank base
   localparam logic [7:0] KEY_A      = 8'hAA;
   localparam logic [7:0] KEY_B      = 8'h55;
   localparam logic [7:0] CMD_ERASE  = 8'h80;
   localparam logic [7:0] CMD_PROG   = 8'hA0;
   localparam logic [7:0] CMD_CHIP   = 8'h30;
   localparam logic [7:0] ERASED     = 8'hFF;
   localparam int         KEY_A_OFS  = 'h555;
   localparam int         KEY_B_OFS  = 'h2AA;
endpackage

// File: rtl/fsq_cmd_step.sv
`timescale 1ns/1ps
module fsq_cmd_step
   import fsq_pkg::*;
#(
   parameter int OFS_W = 13
) (
   input  logic             is_prog_i,
   input  logic [2:0]       step_i,
   input  logic [OFS_W-1:0] byte_ofs_i,
   input  logic [7:0]       src_byte_i,
   output logic [OFS_W-1:0] ofs_o,
   output logic [7:0]       data_o,
   output logic             last_o
);
   localparam logic [OFS_W-1:0] OFS_A = OFS_W'(KEY_A_OFS);
   localparam logic [OFS_W-1:0] OFS_B = OFS_W'(KEY_B_OFS);

   always_comb begin
      ofs_o  = '0;
      data_o = '0;
      last_o = 1'b0;
      unique case (step_i)
         3'd0: begin ofs_o = OFS_A; data_o = KEY_A; end
         3'd1: begin ofs_o = OFS_B; data_o = KEY_B; end
         3'd2: begin ofs_o = OFS_A; data_o = is_prog_i ? CMD_PROG : CMD_ERASE; end
         3'd3: begin
            if (is_prog_i) begin
               ofs_o  = byte_ofs_i;
               data_o = src_byte_i;
               last_o = 1'b1;
            end else begin
               ofs_o  = OFS_A;
               data_o = KEY_A;
            end
         end
         3'd4: begin ofs_o = OFS_B; data_o = KEY_B; end
         3'd5: begin ofs_o = '0; data_o = CMD_CHIP; last_o = 1'b1; end
         default: begin ofs_o = '0; data_o = '0; last_o = 1'b1; end
      endcase
   end
endmodule

// File: rtl/fsq_poll_ctr.sv
`timescale 1ns/1ps
module fsq_poll_ctr #(
   parameter int LIMIT = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic tick_i,
   output logic last_o
);
   generate
      if (LIMIT <= 1) begin : g_single
         assign last_o = 1'b1;
      end else begin : g_count
         localparam int CNT_W = $clog2(LIMIT);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cnt_q <= '0;
            else if (clr_i)   cnt_q <= '0;
            else if (tick_i)  cnt_q <= cnt_q + 1'b1;
         end
         assign last_o = (cnt_q == CNT_W'(LIMIT - 1));
      end
   endgenerate
endmodule

// File: rtl/flash_bank_seq.sv
`timescale 1ns/1ps
module flash_bank_seq
   import fsq_pkg::*;
#(
   parameter int BANK_BYTES    = 8192,
   parameter int BANKS         = 2,
   parameter int TIMEOUT_POLLS = 1000000,
   parameter int TOGGLE_BIT    = 6,
   localparam int OFS_W  = $clog2(BANK_BYTES),
   localparam int SEL_W  = (BANKS > 1) ? $clog2(BANKS) : 0,
   localparam int BANK_W = (SEL_W > 0) ? SEL_W : 1,
   localparam int ADDR_W = OFS_W + SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              op_i,
   input  logic [BANK_W-1:0] bank_i,
   output logic [OFS_W-1:0]  src_addr_o,
   input  logic [7:0]        src_data_i,
   output logic [ADDR_W-1:0] flash_addr_o,
   output logic [7:0]        flash_wdata_o,
   output logic              flash_we_o,
   output logic              flash_re_o,
   input  logic [7:0]        flash_rdata_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              timeout_o,
   output logic              verify_fail_o
);
   generate
      if (BANK_BYTES < 2048 || (BANK_BYTES & (BANK_BYTES - 1)) != 0) begin : g_bad_bank
         $error("BANK_BYTES must be a power of two of at least 2048");
      end
      if (TIMEOUT_POLLS < 1) begin : g_bad_tmo
         $error("TIMEOUT_POLLS must be at least 1");
      end
      if (TOGGLE_BIT < 0 || TOGGLE_BIT > 7) begin : g_bad_bit
         $error("TOGGLE_BIT must select a data bit");
      end
   endgenerate

   localparam logic [OFS_W-1:0] OFS_LAST = OFS_W'(BANK_BYTES - 1);

   fsq_state_e        state;
   logic [2:0]        step_q;
   logic [OFS_W-1:0]  ofs_q;
   logic              prog_q;
   logic [BANK_W-1:0] bank_q;
   logic              tog_q;
   logic              done_q, tmo_q, vfail_q;

   logic [OFS_W-1:0]  cmd_ofs, cur_ofs;
   logic [7:0]        cmd_data, vexp;
   logic              cmd_last, toggling, poll_last, ofs_end;

   fsq_cmd_step #(.OFS_W(OFS_W)) u_step (
      .is_prog_i  (prog_q),
      .step_i     (step_q),
      .byte_ofs_i (ofs_q),
      .src_byte_i (src_data_i),
      .ofs_o      (cmd_ofs),
      .data_o     (cmd_data),
      .last_o     (cmd_last)
   );

   fsq_poll_ctr #(.LIMIT(TIMEOUT_POLLS)) u_poll (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (state == S_CMD),
      .tick_i (state == S_POLL_C && toggling),
      .last_o (poll_last)
   );

   assign toggling = tog_q ^ flash_rdata_i[TOGGLE_BIT];
   assign ofs_end  = (ofs_q == OFS_LAST);
   assign vexp     = prog_q ? src_data_i : ERASED;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         step_q  <= '0;
         ofs_q   <= '0;
         prog_q  <= 1'b0;
         bank_q  <= '0;
         tog_q   <= 1'b0;
         done_q  <= 1'b0;
         tmo_q   <= 1'b0;
         vfail_q <= 1'b0;
      end else begin
         unique case (state)
            S_IDLE: begin
               done_q <= 1'b0;
               if (start_i) begin
                  prog_q  <= op_i;
                  bank_q  <= bank_i;
                  step_q  <= '0;
                  ofs_q   <= '0;
                  tmo_q   <= 1'b0;
                  vfail_q <= 1'b0;
                  state   <= S_CMD;
               end
            end
            S_CMD: begin
               if (cmd_last) begin
                  step_q <= '0;
                  state  <= S_POLL_A;
               end else begin
                  step_q <= step_q + 3'd1;
               end
            end
            S_POLL_A: state <= S_POLL_B;
            S_POLL_B: begin
               tog_q <= flash_rdata_i[TOGGLE_BIT];
               state <= S_POLL_C;
            end
            S_POLL_C: begin
               if (!toggling) begin
                  if (prog_q && !ofs_end) begin
                     ofs_q <= ofs_q + 1'b1;
                     state <= S_CMD;
                  end else begin
                     ofs_q <= '0;
                     state <= S_VRD;
                  end
               end else if (poll_last) begin
                  tmo_q  <= 1'b1;
                  done_q <= 1'b1;
                  state  <= S_IDLE;
               end else begin
                  state <= S_POLL_A;
               end
            end
            S_VRD: state <= S_VCMP;
            S_VCMP: begin
               if (flash_rdata_i != vexp) begin
                  vfail_q <= 1'b1;
                  done_q  <= 1'b1;
                  state   <= S_IDLE;
               end else if (ofs_end) begin
                  done_q <= 1'b1;
                  state  <= S_IDLE;
               end else begin
                  ofs_q <= ofs_q + 1'b1;
                  state <= S_VRD;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (state)
         S_CMD:   cur_ofs = cmd_ofs;
         S_VRD:   cur_ofs = ofs_q;
         default: cur_ofs = '0;
      endcase
   end

   generate
      if (SEL_W > 0) begin : g_multi_bank
         assign flash_addr_o = {bank_q[SEL_W-1:0], cur_ofs};
      end else begin : g_single_bank
         assign flash_addr_o = cur_ofs;
      end
   endgenerate

   assign flash_we_o    = (state == S_CMD);
   assign flash_wdata_o = (state == S_CMD) ? cmd_data : 8'h00;
   assign flash_re_o    = (state == S_POLL_A) || (state == S_POLL_B) || (state == S_VRD);
   assign src_addr_o    = ofs_q;
   assign busy_o        = (state != S_IDLE);
   assign done_o        = done_q;
   assign timeout_o     = tmo_q;
   assign verify_fail_o = vfail_q;
endmodule

// File: rtl/fsq_checker.sv
`timescale 1ns/1ps
module fsq_checker #(
   parameter int ADDR_W = 14,
   parameter int OFS_W  = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              timeout_o,
   input logic              verify_fail_o,
   input logic              flash_we_o,
   input logic              flash_re_o,
   input logic [ADDR_W-1:0] flash_addr_o
);
   p_rw_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(flash_we_o && flash_re_o));

   p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> busy_o);

   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> (busy_o || done_o));

   p_we_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (flash_we_o || flash_re_o) |-> busy_o);

   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(timeout_o) && $stable(verify_fail_o)));

   p_one_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(timeout_o && verify_fail_o));

   generate
      if (ADDR_W > OFS_W) begin : g_bank_chk
         p_bank_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_o && $past(busy_o)) |-> (flash_addr_o[ADDR_W-1:OFS_W] == $past(flash_addr_o[ADDR_W-1:OFS_W])));
      end
   endgenerate
endmodule

bind flash_bank_seq fsq_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_i       (start_i),
   .busy_o        (busy_o),
   .done_o        (done_o),
   .timeout_o     (timeout_o),
   .verify_fail_o (verify_fail_o),
   .flash_we_o    (flash_we_o),
   .flash_re_o    (flash_re_o),
   .flash_addr_o  (flash_addr_o)
);

// File: tb/flash_bank_seq_test.sv
`timescale 1ns/1ps
module flash_bank_seq_test;
   localparam int BB = 2048;
   localparam int TP = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        op = 1'b0;
   logic [0:0]  bank = 1'b0;
   logic [10:0] src_addr;
   logic [7:0]  src_data;
   logic [11:0] faddr;
   logic [7:0]  fwdata;
   logic [7:0]  frdata = 8'h00;
   logic        fwe, fre, busy, done, tmo, vfail;

   always #2.5 clk = ~clk;

   flash_bank_seq #(.BANK_BYTES(BB), .BANKS(2), .TIMEOUT_POLLS(TP)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .bank_i(bank),
      .src_addr_o(src_addr), .src_data_i(src_data),
      .flash_addr_o(faddr), .flash_wdata_o(fwdata), .flash_we_o(fwe),
      .flash_re_o(fre), .flash_rdata_i(frdata),
      .busy_o(busy), .done_o(done), .timeout_o(tmo), .verify_fail_o(vfail)
   );

   logic [7:0]  src [BB];
   logic [7:0]  mem [2*BB];
   logic [19:0] expq[$];
   assign src_data = src[src_addr];

   int total = 0, bad = 0, reads = 0, cyc = 0;
   int busy_left = 0, prog_busy = 2, erase_busy = 6;
   int corrupt_ofs = -1, stuck_ofs = -1, cur_bank = 0;
   bit tog = 1'b0;
   logic [19:0] h1 = '0, h2 = '0, h3 = '0;
   logic        l_we = 1'b0, l_re = 1'b0;
   logic [11:0] l_addr = '0;
   logic [7:0]  l_data = '0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // flash model: request captured mid-cycle, applied at the next edge
   always @(negedge clk) begin
      l_we = fwe; l_re = fre; l_addr = faddr; l_data = fwdata;
      if (fwe) begin
         if (expq.size() == 0) chk(1'b0, "R3 R4 unexpected write", int'({faddr, fwdata}), -1);
         else begin
            logic [19:0] e;
            e = expq.pop_front();
            chk(e == {faddr, fwdata}, "R3 R4 write sequence", int'({faddr, fwdata}), int'(e));
         end
      end
      if (busy && (fwe || fre))
         chk(int'(faddr[11]) == cur_bank, "R10 bank of access", int'(faddr[11]), cur_bank);
      if (fwe && fre) chk(1'b0, "R10 read and write together", 1, 0);
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
      if (l_we) begin
         int o, b;
         logic [7:0] v;
         o = int'(l_addr[10:0]);
         b = int'(l_addr[11]);
         if (h1 == {l_addr[11], 11'h555, 8'hA0} && h2[7:0] == 8'h55 && h3[7:0] == 8'hAA) begin
            v = mem[l_addr] & l_data;
            if (o == corrupt_ofs) v = v ^ 8'h01;
            mem[l_addr] = v;
            busy_left = prog_busy;
            h1 = '0; h2 = '0; h3 = '0;
         end else if (o == 0 && l_data == 8'h30 && h1[7:0] == 8'h55 && h2[7:0] == 8'hAA
                      && h3 == {l_addr[11], 11'h555, 8'h80}) begin
            for (int k = 0; k < BB; k++) mem[b*BB + k] = (k == stuck_ofs) ? 8'h00 : 8'hFF;
            busy_left = erase_busy;
            h1 = '0; h2 = '0; h3 = '0;
         end else begin
            h3 = h2; h2 = h1; h1 = {l_addr, l_data};
         end
      end
      if (l_re) begin
         reads++;
         if (busy_left > 0) begin
            frdata <= {1'b0, tog, 6'b0};
            tog = ~tog;
            busy_left--;
         end else begin
            frdata <= mem[l_addr];
         end
      end
   end

   task automatic push_erase(input int b);
      logic bb;
      bb = b[0];
      expq.push_back({bb, 11'h555, 8'hAA});
      expq.push_back({bb, 11'h2AA, 8'h55});
      expq.push_back({bb, 11'h555, 8'h80});
      expq.push_back({bb, 11'h555, 8'hAA});
      expq.push_back({bb, 11'h2AA, 8'h55});
      expq.push_back({bb, 11'h000, 8'h30});
   endtask

   task automatic push_prog(input int b);
      logic bb;
      bb = b[0];
      for (int i = 0; i < BB; i++) begin
         expq.push_back({bb, 11'h555, 8'hAA});
         expq.push_back({bb, 11'h2AA, 8'h55});
         expq.push_back({bb, 11'h555, 8'hA0});
         expq.push_back({bb, 11'(i), src[i]});
      end
   endtask

   task automatic fill_src(input int seed);
      for (int i = 0; i < BB; i++) src[i] = 8'((i * seed) + (i >> 3) + seed);
   endtask

   task automatic wait_done(output bit t, output bit v);
      while (done !== 1'b1) @(negedge clk);
      t = tmo; v = vfail;
      chk(busy == 1'b0, "R9 done while idle", int'(busy), 0);
      chk(expq.size() == 0, "R3 R4 all writes issued", expq.size(), 0);
      expq.delete();
      @(negedge clk);
      chk(done == 1'b0, "R9 done is one pulse", int'(done), 0);
   endtask

   task automatic run_op(input bit o, input int b, output bit t, output bit v);
      if (o) push_prog(b); else push_erase(b);
      @(negedge clk);
      cur_bank = b;
      start = 1'b1; op = o; bank = b[0];
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
      chk(tmo == 1'b0 && vfail == 1'b0, "R9 flags cleared after start", int'({tmo, vfail}), 0);
      wait_done(t, v);
   endtask

   function automatic int bank_diff_src(input int b);
      int n = 0;
      for (int i = 0; i < BB; i++) if (mem[b*BB + i] !== src[i]) n++;
      return n;
   endfunction

   initial begin
      bit t, v;
      int r0, nd;
      fill_src(7);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({busy, done, tmo, vfail, fwe, fre} == 6'b0, "R1 reset outputs",
          int'({busy, done, tmo, vfail, fwe, fre}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, done, tmo, vfail, fwe, fre} == 6'b0, "R1 idle after reset",
          int'({busy, done, tmo, vfail, fwe, fre}), 0);

      // R3 R5 R7 erase bank 0: 6 busy reads then a settled pair, then full read-back
      r0 = reads;
      run_op(1'b0, 0, t, v);
      chk(t == 0 && v == 0, "R7 erase bank 0 clean", int'({t, v}), 0);
      chk(reads - r0 == 8 + BB, "R5 poll and verify read count", reads - r0, 8 + BB);

      // R4 R8 program bank 0
      run_op(1'b1, 0, t, v);
      chk(t == 0 && v == 0, "R8 program bank 0 clean", int'({t, v}), 0);
      chk(bank_diff_src(0) == 0, "R4 bank 0 holds source", bank_diff_src(0), 0);

      // R2 start while busy ignored
      push_erase(1);
      @(negedge clk);
      cur_bank = 1;
      start = 1'b1; op = 1'b0; bank = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      start = 1'b1; op = 1'b1; bank = 1'b0;
      @(negedge clk);
      start = 1'b0;
      wait_done(t, v);
      chk(t == 0 && v == 0, "R2 erase unaffected by busy start", int'({t, v}), 0);
      chk(bank_diff_src(0) == 0, "R2 bank 0 untouched by ignored start", bank_diff_src(0), 0);

      // R8 program bank 1 with a bad cell at offset 100: stops there
      fill_src(13);
      corrupt_ofs = 100;
      r0 = reads;
      run_op(1'b1, 1, t, v);
      corrupt_ofs = -1;
      chk(v == 1 && t == 0, "R8 program mismatch flagged", int'({t, v}), 1);
      chk(reads - r0 == 4*BB + 101, "R8 stop at first mismatch", reads - r0, 4*BB + 101);

      // R9 flag held while idle
      repeat (10) @(negedge clk);
      chk(vfail == 1'b1, "R9 verify flag held", int'(vfail), 1);

      // R7 erase bank 1 with a stuck byte at offset 5
      stuck_ofs = 5;
      r0 = reads;
      run_op(1'b0, 1, t, v);
      stuck_ofs = -1;
      chk(v == 1 && t == 0, "R7 erase mismatch flagged", int'({t, v}), 1);
      chk(reads - r0 == 8 + 6, "R7 erase stops at first mismatch", reads - r0, 14);

      // R6 timeout: busy for 2*TP reads
      erase_busy = 2*TP;
      r0 = reads;
      run_op(1'b0, 0, t, v);
      chk(t == 1 && v == 0, "R6 timeout flagged", int'({t, v}), 2);
      chk(reads - r0 == 2*TP, "R6 timeout poll count", reads - r0, 2*TP);

      // R6 completion on the last allowed poll pair wins
      erase_busy = 2*TP - 2;
      r0 = reads;
      run_op(1'b0, 0, t, v);
      chk(t == 0 && v == 0, "R6 last-poll completion", int'({t, v}), 0);
      chk(reads - r0 == 2*TP + BB, "R6 last-poll read count", reads - r0, 2*TP + BB);
      erase_busy = 6;

      // R2 R9 start in the same cycle as done
      fill_src(29);
      push_erase(1);
      push_prog(1);
      @(negedge clk);
      cur_bank = 1;
      start = 1'b1; op = 1'b0; bank = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (done !== 1'b1) @(negedge clk);
      chk(tmo == 0 && vfail == 0, "R7 erase before back-to-back", int'({tmo, vfail}), 0);
      start = 1'b1; op = 1'b1; bank = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2 start on done cycle accepted", int'(busy), 1);
      chk(done == 1'b0, "R9 no second pulse", int'(done), 0);
      wait_done(t, v);
      chk(t == 0 && v == 0, "R8 back-to-back program clean", int'({t, v}), 0);
      nd = bank_diff_src(1);
      chk(nd == 0, "R4 bank 1 holds source", nd, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule